// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is a 7-bit-address I2C target that runs entirely from a fast system clock. It oversamples the SCL and SDA lines through synchronizers, finds START and STOP conditions, collects the address byte and the direction bit, and acknowledges when the address equals the value on `own_addr`. Both directions of data pass through one holding buffer that a host reads and writes through a small strobe interface. SCL and SDA are open-drain, so the block only produces drive-low enables.

On writes from the bus controller, each completed byte is accepted or refused depending on the buffer-full and overflow flags, and a per-byte interrupt flag tells the host to service the buffer. On reads, the block holds SCL low after the address and after every byte the controller acknowledges. It lets go of the line only when the host has loaded the next byte and sets the clock-release bit.

Top module: `i2c_target_stretch`

## Requirements
- R1: START (SDA falling while SCL is high) arms address reception. After STOP (SDA rising while SCL is high), bus clocking is ignored until the next START, and no ACK is given.
- R2: The address byte arrives MSB first: 7 address bits, then the direction bit (1 = read). On a match the block pulls SDA low from the 8th SCL falling edge to the 9th. On a mismatch it gives no ACK and ignores the bus until the next START or STOP. `rw_flag` takes the direction bit of a matched address.
- R3: A received data byte that completes with `buf_full`=0 and `ovf_flag`=0 is copied into the buffer, sets `buf_full` and is ACKed.
- R4: A received data byte that completes with `buf_full`=1 leaves the buffer unchanged, is not ACKed and sets `ovf_flag`. This holds whether `ovf_flag` was 0 or 1.
- R5: A received data byte that completes with `buf_full`=0 and `ovf_flag`=1 is copied into the buffer and sets `buf_full`, but is not ACKed.
- R6: `ovf_flag` is cleared only by a pulse on `ovf_clr`. A pulse on `host_rd` clears `buf_full`.
- R7: A read-address match sets `rw_flag`, loads the address byte (address in bits 7:1, a 1 in bit 0) into the buffer, ACKs, and from the 9th SCL falling edge holds SCL low with `rel_bit`=0.
- R8: `host_wr` loads the buffer and, in read mode, the transmit shift register, and sets `buf_full`. SCL stays held until a `rel_set` pulse sets `rel_bit`. `buf_full` clears once the last data bit has been shifted out.
- R9: Transmit bits go out MSB first. SDA changes only after an SCL falling edge and is stable for the whole SCL high time.
- R10: `irq_flag` is set at the 9th SCL falling edge of every byte, including a matched address byte, and is cleared by `irq_clr`.
- R11: In transmit, the controller's bit is latched at the 9th SCL rising edge. An ACK (low) makes the block hold SCL low again, awaiting reload and release. A NACK (high) clears `rw_flag`, releases the bus and ignores clocking until the next START.
- R12: After reset, neither line is driven, `buf_full`, `ovf_flag`, `irq_flag` and `rw_flag` are 0, and `rel_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (stretching) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data 0) |
| host_wr | input | 1 | Strobe: write `host_wdata` into the buffer |
| host_wdata | input | 8 | Data written by the host |
| host_rd | input | 1 | Strobe: host has taken the buffer |
| host_rdata | output | 8 | Buffer contents |
| ovf_clr | input | 1 | Strobe: clear the overflow flag |
| irq_clr | input | 1 | Strobe: clear the interrupt flag |
| rel_set | input | 1 | Strobe: set the clock-release bit |
| buf_full | output | 1 | Buffer holds unserviced data |
| ovf_flag | output | 1 | A byte arrived while the buffer was full |
| irq_flag | output | 1 | A byte transfer finished |
| rel_bit | output | 1 | Clock-release bit (0 = holding SCL) |
| rw_flag | output | 1 | Direction of the current matched transfer |

## Verification
The bench runs the four combinations of buffer-full and overflow through one write transaction. A design that confused them would ACK a refused byte, overwrite an unread byte, or drop the byte that should land after a host read with overflow still set. It checks that SCL stays low after a host write alone and is freed only by the release strobe; a design that released early would let the controller clock out stale data. It watches SDA at three points of every SCL high time during transmit, which exposes a design that shifts on the rising edge. It also confirms that clocking after STOP, after an address mismatch and after a controller NACK draws no ACK, which a design that failed to go back to waiting for START would give.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX_WAIT,
        ST_TX,
        ST_TX_ACK
    } eng_state_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            stg_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl  = stg_q[STAGES-1];
    assign rise = stg_q[STAGES-1] & ~prev_q;
    assign fall = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);

    logic [1:0] lvl_w, rise_w, fall_w;
    logic       scl_prev_q;

    i2ct_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .lvl      (lvl_w),
        .rise     (rise_w),
        .fall     (fall_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_prev_q <= 1'b1;
        else        scl_prev_q <= lvl_w[1];
    end

    assign scl_lvl  = lvl_w[1];
    assign sda_lvl  = lvl_w[0];
    assign scl_rise = rise_w[1];
    assign scl_fall = fall_w[1];
    // a line condition needs SCL high now and one cycle before
    assign ev_start = fall_w[0] & lvl_w[1] & scl_prev_q;
    assign ev_stop  = rise_w[0] & lvl_w[1] & scl_prev_q;

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
    import i2ct_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    input  logic              rel_set,
    output logic              buf_full,
    output logic              ovf_flag,
    output logic              irq_flag,
    output logic              rel_bit,
    output logic              rw_flag
);

    localparam int               CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] hold;
        logic              full;
        logic              ovf;
        logic              irq;
        logic              rel;
        logic              rw;
        logic              sda;
        logic              mack;
    } eng_t;

    eng_t eng_d, eng_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;

    i2ct_bus_events #(.STAGES(SYNC_STAGES)) bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    always_comb begin
        eng_d = eng_q;
        // host side first; bus events below take precedence
        if (host_rd) eng_d.full = 1'b0;
        if (ovf_clr) eng_d.ovf  = 1'b0;
        if (irq_clr) eng_d.irq  = 1'b0;
        if (rel_set) eng_d.rel  = 1'b1;
        if (host_wr) begin
            eng_d.hold = host_wdata;
            if (eng_q.rw) begin
                eng_d.sh   = host_wdata;
                eng_d.full = 1'b1;
            end
        end

        if (ev_start) begin
            eng_d.st  = ST_ADDR;
            eng_d.cnt = '0;
            eng_d.sda = 1'b0;
        end else if (ev_stop) begin
            eng_d.st  = ST_IDLE;
            eng_d.sda = 1'b0;
        end else begin
            unique case (eng_q.st)
                ST_IDLE: ;
                ST_ADDR, ST_RX: begin
                    if (scl_rise && eng_q.cnt < LAST) begin
                        eng_d.sh  = {eng_q.sh[DATA_W-2:0], sda_lvl};
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall && eng_q.cnt == LAST) begin
                        if (eng_q.st == ST_ADDR) begin
                            if (eng_q.sh[DATA_W-1:1] == own_addr) begin
                                eng_d.sda = 1'b1;
                                eng_d.rw  = eng_q.sh[0];
                                if (eng_q.sh[0]) eng_d.hold = eng_q.sh;
                                eng_d.st  = ST_ADDR_ACK;
                            end else begin
                                eng_d.st = ST_IDLE;
                            end
                        end else begin
                            if (eng_q.full) begin
                                eng_d.ovf = 1'b1;
                            end else begin
                                eng_d.hold = eng_q.sh;
                                eng_d.full = 1'b1;
                            end
                            eng_d.sda = !eng_q.full && !eng_q.ovf;
                            eng_d.st  = ST_RX_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        eng_d.sda = 1'b0;
                        eng_d.irq = 1'b1;
                        if (eng_q.rw) begin
                            eng_d.rel = 1'b0;
                            eng_d.st  = ST_TX_WAIT;
                        end else begin
                            eng_d.cnt = '0;
                            eng_d.st  = ST_RX;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        eng_d.sda = 1'b0;
                        eng_d.irq = 1'b1;
                        eng_d.cnt = '0;
                        eng_d.st  = ST_RX;
                    end
                end
                ST_TX_WAIT: begin
                    // present the first bit in the same cycle SCL is freed
                    if (eng_d.rel) begin
                        eng_d.st  = ST_TX;
                        eng_d.cnt = '0;
                        eng_d.sda = !eng_d.sh[DATA_W-1];
                    end
                end
                ST_TX: begin
                    if (scl_rise && eng_q.cnt < LAST) begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (eng_q.cnt == LAST) begin
                            eng_d.sda  = 1'b0;
                            eng_d.full = 1'b0;
                            eng_d.st   = ST_TX_ACK;
                        end else if (eng_q.cnt != '0) begin
                            eng_d.sh  = {eng_q.sh[DATA_W-2:0], 1'b0};
                            eng_d.sda = !eng_q.sh[DATA_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) eng_d.mack = sda_lvl;
                    if (scl_fall) begin
                        eng_d.irq = 1'b1;
                        if (eng_q.mack) begin
                            eng_d.rw = 1'b0;
                            eng_d.st = ST_IDLE;
                        end else begin
                            eng_d.rel = 1'b0;
                            eng_d.st  = ST_TX_WAIT;
                        end
                    end
                end
                default: eng_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.st   <= ST_IDLE;
            eng_q.rel  <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign scl_drive_low = !eng_q.rel;
    assign sda_drive_low = eng_q.sda;
    assign host_rdata    = eng_q.hold;
    assign buf_full      = eng_q.full;
    assign ovf_flag      = eng_q.ovf;
    assign irq_flag      = eng_q.irq;
    assign rel_bit       = eng_q.rel;
    assign rw_flag       = eng_q.rw;

    // R6: overflow survives every cycle without a host clear
    a_r6_ovf_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R8: once stretching, SCL stays held until the release strobe
    a_r8_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !rel_set) |=> scl_drive_low);

    // R9: transmit data does not move while the sampled SCL is high
    a_r9_tx_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_TX && scl_lvl && !scl_rise) |-> $stable(sda_drive_low));

    // R10: the interrupt flag rises only right after an SCL falling edge
    a_r10_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(scl_fall));

    // R2: SDA is pulled only in acknowledge slots or while transmitting
    a_r2_sda_owner: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (eng_q.st inside {ST_ADDR_ACK, ST_RX_ACK, ST_TX}));

endmodule

// File: tb/i2c_target_stretch_tb_top.sv
`timescale 1ns/1ps
module i2c_target_stretch_tb_top;

    localparam int HALF = 20;
    localparam logic [6:0] MY_ADDR = 7'h5B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_bus, sda_bus;
    logic       scl_drive_low, sda_drive_low;
    logic       host_wr = 1'b0, host_rd = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0, rel_set = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       buf_full, ovf_flag, irq_flag, rel_bit, rw_flag;

    assign scl_bus = !(m_scl_low || scl_drive_low);
    assign sda_bus = !(m_sda_low || sda_drive_low);

    i2c_target_stretch dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
        .rel_set(rel_set), .buf_full(buf_full), .ovf_flag(ovf_flag),
        .irq_flag(irq_flag), .rel_bit(rel_bit), .rw_flag(rw_flag)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; cyc(1); s = 1'b0;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; wait_scl_high(); cyc(HALF);
        m_sda_low = 1'b1; cyc(HALF);
        m_scl_low = 1'b1; cyc(HALF);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; cyc(HALF);
        m_scl_low = 1'b0; wait_scl_high(); cyc(HALF);
        m_sda_low = 1'b0; cyc(HALF);
    endtask

    task automatic send_bit(input logic b, output logic s);
        m_sda_low = !b; cyc(HALF);
        m_scl_low = 1'b0; wait_scl_high();
        cyc(HALF/2); s = sda_bus; cyc(HALF/2);
        m_scl_low = 1'b1; cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(d[i], s);
        send_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d, output int unstable);
        logic s1, s2, s3;
        unstable = 0;
        m_sda_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cyc(HALF);
            m_scl_low = 1'b0; wait_scl_high();
            s1 = sda_bus; cyc(HALF/2); s2 = sda_bus; cyc(HALF/2 - 1); s3 = sda_bus;
            if (s1 !== s2 || s2 !== s3) unstable++;
            d = {d[6:0], s2};
            cyc(1);
            m_scl_low = 1'b1;
        end
        cyc(HALF);
        m_sda_low = give_ack; cyc(HALF);
        m_scl_low = 1'b0; wait_scl_high(); cyc(HALF);
        m_scl_low = 1'b1; cyc(HALF);
        m_sda_low = 1'b0; cyc(HALF);
    endtask

    typedef struct packed {
        logic       rd;
        logic       clr;
        logic [7:0] data;
        logic       ack;
        logic [7:0] hold;
        logic       full;
        logic       ovf;
    } vec_t;

    // walked in order: each entry starts from the flags the previous one left
    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 8'hA5, 1'b1, 8'hA5, 1'b1, 1'b0},  // R3 empty, no overflow
        '{1'b0, 1'b0, 8'h3C, 1'b0, 8'hA5, 1'b1, 1'b1},  // R4 still full
        '{1'b1, 1'b0, 8'h7E, 1'b0, 8'h7E, 1'b1, 1'b1},  // R5 read, overflow kept
        '{1'b0, 1'b0, 8'h11, 1'b0, 8'h7E, 1'b1, 1'b1},  // R4 full and overflow
        '{1'b1, 1'b1, 8'hC3, 1'b1, 8'hC3, 1'b1, 1'b0}   // R3 after R6 clears
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       acked;
        logic [7:0] d;
        int         unst;

        cyc(10);
        chk("R12 scl drive", scl_drive_low, 0);
        chk("R12 sda drive", sda_drive_low, 0);
        chk("R12 full", buf_full, 0);
        chk("R12 ovf", ovf_flag, 0);
        chk("R12 irq", irq_flag, 0);
        chk("R12 rw", rw_flag, 0);
        chk("R12 rel", rel_bit, 1);
        rst_n = 1'b1;
        cyc(10);

        // R2: wrong address gets no ACK, then the rest is ignored
        bus_start();
        send_byte(8'h20, acked);
        chk("R2 mismatch nack", acked, 0);
        send_byte({MY_ADDR, 1'b0}, acked);
        chk("R2 ignored after mismatch", acked, 0);
        chk("R2 no irq on mismatch", irq_flag, 0);
        bus_stop();

        // R2/R10: matching write address
        bus_start();
        send_byte({MY_ADDR, 1'b0}, acked);
        chk("R2 write addr ack", acked, 1);
        chk("R2 rw low", rw_flag, 0);
        chk("R10 irq on address", irq_flag, 1);

        for (int i = 0; i < 5; i++) begin
            if (VECS[i].rd)  pulse(host_rd);
            if (VECS[i].clr) pulse(ovf_clr);
            pulse(irq_clr);
            send_byte(VECS[i].data, acked);
            chk($sformatf("R3/R4/R5 ack v%0d", i), acked, VECS[i].ack);
            chk($sformatf("R3/R4/R5 buffer v%0d", i), host_rdata, VECS[i].hold);
            chk($sformatf("R6 full v%0d", i), buf_full, VECS[i].full);
            chk($sformatf("R4/R6 ovf v%0d", i), ovf_flag, VECS[i].ovf);
            chk($sformatf("R10 irq v%0d", i), irq_flag, 1);
        end
        bus_stop();

        // R1: clocking after STOP without START is ignored
        m_scl_low = 1'b1; cyc(HALF);
        send_byte({MY_ADDR, 1'b0}, acked);
        chk("R1 no ack after stop", acked, 0);

        // R7: read address match and stretching
        pulse(host_rd);
        pulse(irq_clr);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, acked);
        chk("R7 read addr ack", acked, 1);
        chk("R7 scl held", scl_drive_low, 1);
        chk("R7 rel cleared", rel_bit, 0);
        chk("R7 rw set", rw_flag, 1);
        chk("R7 addr in buffer", host_rdata, {MY_ADDR, 1'b1});
        chk("R10 irq on read addr", irq_flag, 1);

        host_wdata = 8'h96; pulse(host_wr);
        cyc(40);
        chk("R8 still held after write", scl_drive_low, 1);
        chk("R8 full after write", buf_full, 1);
        pulse(rel_set);
        cyc(1);
        chk("R8 released", scl_drive_low, 0);
        pulse(irq_clr);
        recv_byte(1'b1, d, unst);
        chk("R9 tx byte", d, 8'h96);
        chk("R9 sda stable while high", unst, 0);
        chk("R8 full cleared after shift", buf_full, 0);
        chk("R10 irq after tx byte", irq_flag, 1);
        chk("R11 held again after ack", scl_drive_low, 1);

        host_wdata = 8'h5A; pulse(host_wr);
        pulse(rel_set);
        recv_byte(1'b0, d, unst);
        chk("R9 second tx byte", d, 8'h5A);
        chk("R9 second byte stable", unst, 0);
        chk("R11 released after nack", scl_drive_low, 0);
        chk("R11 rw cleared", rw_flag, 0);
        send_byte(8'h00, acked);
        chk("R11 idle after nack", acked, 0);
        bus_stop();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule